// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, counter-timed stand-in for a retriggerable monostable. It has three qualified trigger sources. The first is a falling edge on an active-low trigger input while the active-high trigger and the clear are high. The second is a rising edge on the active-high trigger while the active-low trigger is low and clear is high. The third is the release of clear, when clear rises while the active-low trigger is low and the active-high trigger is high. Any of these drives the output high for a width that is sampled from a 16-bit input at the moment of the trigger.

If a qualified edge arrives while the pulse is high, the timing restarts from the width sampled at that edge. The pulse therefore lasts until a full width has passed after the last trigger. Pulling clear low ends the pulse at the next clock. It also starts a lockout window of `RECOV` cycles, and any trigger edge that falls inside that window is ignored. The complementary output is a register of its own and is always the inverse of the main output.

Top module: `oneshot_retrig`

## Requirements
- R1: After reset, and whenever no pulse is running, `q_o` is 0 and `q_no` is 1.
- R2: A 1-to-0 change of `trig_ni` between two clock edges, with `trig_i`=1 and `clr_ni`=1 at the second edge and no lockout pending, sets `q_o` to 1 right after that second edge.
- R3: A 0-to-1 change of `trig_i`, with `trig_ni`=0 and `clr_ni`=1 at the sampling edge and no lockout pending, sets `q_o` to 1 right after that edge.
- R4: A 0-to-1 change of `clr_ni`, with `trig_ni`=0 and `trig_i`=1 at the sampling edge, sets `q_o` to 1 right after that edge, provided the lockout has expired.
- R5: Input changes that do not meet the qualifiers in R2 to R4 have no effect on the outputs. Examples are a rise of `trig_i` while `trig_ni`=1, a fall of `trig_ni` while `trig_i`=0, and a fall of `trig_i`.
- R6: A trigger sampled with `width_i`=W keeps `q_o` high for exactly W+1 clock cycles. With W=0 the pulse is one cycle long.
- R7: A qualified trigger while `q_o` is 1 reloads the timer with the `width_i` value present at that edge. `q_o` then stays high for W+1 cycles after that last trigger.
- R8: `clr_ni`=0 at a clock edge forces `q_o` to 0 right after that edge. This takes priority over any running pulse.
- R9: If the edge at which `clr_ni` is first sampled 0 is edge E, every trigger sampled at edges E+1 through E+RECOV is ignored. A trigger at edge E+RECOV+1 or later is honoured.
- R10: `q_no` is the inverse of `q_o` at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_ni | input | 1 | Trigger that is active on its falling edge |
| trig_i | input | 1 | Trigger that is active on its rising edge |
| clr_ni | input | 1 | Clear, active low; its release is a trigger source |
| width_i | input | WIDTH_W (16) | Pulse width minus one, in clock cycles |
| q_o | output | 1 | Pulse output |
| q_no | output | 1 | Registered complement of the pulse output |

## Verification
The assertions assume that all three control inputs are already synchronous to `clk_i` and are stable around the rising edge. They also assume that `width_i` is only meaningful at an edge where a trigger qualifies. The stimulus changes inputs only on the falling clock edge and holds each input combination for at least one full cycle. Clear pulses of one cycle and of several cycles are both applied, so that the lockout window is crossed from both sides.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // which qualified source fired this cycle
  typedef struct packed {
    logic fall_lo;   // active-low trigger fell
    logic rise_hi;   // active-high trigger rose
    logic clr_rel;   // clear released
  } trig_src_t;

  localparam int unsigned DEF_WIDTH_W = 16;
  localparam int unsigned DEF_RECOV   = 4;

endpackage

// File: rtl/oneshot_trig_det.sv
module oneshot_trig_det
  import oneshot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      trig_ni,
  input  logic      trig_i,
  input  logic      clr_ni,
  output trig_src_t src_o,
  output logic      clr_fall_o
);

  logic lo_q, hi_q, clr_q;

  // reset to quiescent levels so no edge is seen at reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= 1'b1;
      hi_q  <= 1'b0;
      clr_q <= 1'b1;
    end else begin
      lo_q  <= trig_ni;
      hi_q  <= trig_i;
      clr_q <= clr_ni;
    end
  end

  always_comb begin
    src_o.fall_lo = lo_q  & ~trig_ni & trig_i  & clr_ni;
    src_o.rise_hi = ~hi_q & trig_i   & ~trig_ni & clr_ni;
    src_o.clr_rel = ~clr_q & clr_ni  & ~trig_ni & trig_i;
    clr_fall_o    = clr_q & ~clr_ni;
  end

endmodule

// File: rtl/oneshot_lockout.sv
module oneshot_lockout #(
  parameter int unsigned RECOV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_fall_i,
  output logic ready_o
);

  generate
    if (RECOV == 0) begin : g_none
      assign ready_o = 1'b1;
    end else begin : g_cnt
      localparam int unsigned LW = $clog2(RECOV + 1);
      logic [LW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (clr_fall_i) begin
          cnt_q <= LW'(RECOV);
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign ready_o = (cnt_q == '0);
    end
  endgenerate

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int unsigned WIDTH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_ni,
  input  logic               load_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               q_no
);

  logic [WIDTH_W-1:0] cnt_q, cnt_d;
  logic               q_q, q_d;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (!clr_ni) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (load_i) begin
      cnt_d = width_i;
      q_d   = 1'b1;
    end else if (q_q) begin
      if (cnt_q == '0) q_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
      q_no  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
      q_no  <= ~q_d;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/oneshot_retrig.sv
module oneshot_retrig
  import oneshot_pkg::*;
#(
  parameter int unsigned WIDTH_W = DEF_WIDTH_W,
  parameter int unsigned RECOV   = DEF_RECOV
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_ni,
  input  logic               trig_i,
  input  logic               clr_ni,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               q_o,
  output logic               q_no
);

  trig_src_t src;
  logic      clr_fall, ready, accept;

  oneshot_trig_det u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_ni    (trig_ni),
    .trig_i     (trig_i),
    .clr_ni     (clr_ni),
    .src_o      (src),
    .clr_fall_o (clr_fall)
  );

  oneshot_lockout #(.RECOV(RECOV)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_fall_i (clr_fall),
    .ready_o    (ready)
  );

  assign accept = (|src) & ready;

  oneshot_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_ni  (clr_ni),
    .load_i  (accept),
    .width_i (width_i),
    .q_o     (q_o),
    .q_no    (q_no)
  );

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk #(
  parameter int unsigned WIDTH_W = 16,
  parameter int unsigned RECOV   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trig_ni,
  input logic               trig_i,
  input logic               clr_ni,
  input logic [WIDTH_W-1:0] width_i,
  input logic               q_o,
  input logic               q_no
);

  localparam int unsigned LW = $clog2(RECOV + 2);

  logic          lo_p, hi_p, clr_p;
  logic [LW-1:0] win_q;
  logic          free, e_lo, e_hi, e_clr, any_e, acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_p  <= 1'b1;
      hi_p  <= 1'b0;
      clr_p <= 1'b1;
      win_q <= '0;
    end else begin
      lo_p  <= trig_ni;
      hi_p  <= trig_i;
      clr_p <= clr_ni;
      if (clr_p && !clr_ni)  win_q <= LW'(RECOV);
      else if (win_q != '0)  win_q <= win_q - 1'b1;
    end
  end

  assign free  = (win_q == '0);
  assign e_lo  = lo_p && !trig_ni && trig_i && clr_ni;
  assign e_hi  = !hi_p && trig_i && !trig_ni && clr_ni;
  assign e_clr = !clr_p && clr_ni && !trig_ni && trig_i;
  assign any_e = e_lo || e_hi || e_clr;
  assign acc   = any_e && free;

  a_r10_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o != q_no);

  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> !q_o);

  a_r2_low_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_lo && free) |=> q_o);

  a_r3_high_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_hi && free) |=> q_o);

  a_r4_clear_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_clr && free) |=> q_o);

  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_o && !any_e) |=> !q_o);

  a_r9_lockout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!free && !q_o) |=> !q_o);

  a_r6_zero_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && width_i == '0) ##1 !acc |=> !q_o);

endmodule

bind oneshot_retrig oneshot_chk #(.WIDTH_W(WIDTH_W), .RECOV(RECOV)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_ni (trig_ni),
  .trig_i  (trig_i),
  .clr_ni  (clr_ni),
  .width_i (width_i),
  .q_o     (q_o),
  .q_no    (q_no)
);

// File: tb/oneshot_retrig_bench.sv
module oneshot_retrig_bench;

  localparam int unsigned WW = 16;
  localparam int unsigned RC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          t_lo = 1'b1, t_hi = 1'b0, clr_n = 1'b1;
  logic [WW-1:0] width = '0;
  logic          q, qn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic  q;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference model state, derived from the requirements
  logic m_lo = 1'b1, m_hi = 1'b0, m_clr = 1'b1, m_q = 1'b0;
  int   m_cnt = 0, m_lock = 0;

  always #2 clk = ~clk;

  oneshot_retrig #(.WIDTH_W(WW), .RECOV(RC)) u_oneshot_retrig (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .trig_ni (t_lo),
    .trig_i  (t_hi),
    .clr_ni  (clr_n),
    .width_i (width),
    .q_o     (q),
    .q_no    (qn)
  );

  task automatic step(input logic lo, input logic hi, input logic cl,
                      input int w, input string tag);
    logic trg;
    @(negedge clk);
    t_lo = lo; t_hi = hi; clr_n = cl; width = WW'(w);
    trg = (m_lo && !lo && hi && cl) || (!m_hi && hi && !lo && cl) ||
          (!m_clr && cl && !lo && hi);
    if (!cl) begin
      m_q = 1'b0; m_cnt = 0;
    end else if (trg && m_lock == 0) begin
      m_q = 1'b1; m_cnt = w;
    end else if (m_q) begin
      if (m_cnt == 0) m_q = 1'b0;
      else            m_cnt--;
    end
    if (m_clr && !cl)     m_lock = RC;
    else if (m_lock > 0)  m_lock--;
    m_lo = lo; m_hi = hi; m_clr = cl;
    @(posedge clk);
    #1 sb.push_back('{q: m_q, tag: tag});
  endtask

  task automatic idle(input logic lo, input logic hi, input int n, input string tag);
    for (int i = 0; i < n; i++) step(lo, hi, 1'b1, 0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (q !== e.q || qn !== ~e.q) begin
        n_fail++;
        $display("FAIL %s: q_o=%b q_no=%b expected q_o=%b q_no=%b",
                 e.tag, q, qn, e.q, ~e.q);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (q !== 1'b0 || qn !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: q_o=%b q_no=%b expected 0 1", q, qn);
    end
    rst_n = 1'b1;
    idle(1'b1, 1'b0, 3, "R1 idle");
    // R5: trig_i rises while trig_ni is high
    step(1'b1, 1'b1, 1'b1, 7, "R5 hi rise blocked");
    idle(1'b1, 1'b1, 2, "R5 hold");
    // R2: trig_ni falls, width 3 -> 4 cycles
    step(1'b0, 1'b1, 1'b1, 3, "R2 low fall");
    idle(1'b0, 1'b1, 6, "R6 width 3");
    // R6: width 0
    idle(1'b1, 1'b1, 1, "R6 setup");
    step(1'b0, 1'b1, 1'b1, 0, "R6 zero width");
    idle(1'b0, 1'b1, 3, "R6 zero tail");
    // R5: trig_i falls, trig_ni falls with trig_i low
    step(1'b0, 1'b0, 1'b1, 5, "R5 hi fall");
    step(1'b1, 1'b0, 1'b1, 5, "R5 lo rise");
    step(1'b0, 1'b0, 1'b1, 5, "R5 lo fall hi low");
    idle(1'b0, 1'b0, 2, "R5 hold");
    // R3: trig_i rises, width 2
    step(1'b0, 1'b1, 1'b1, 2, "R3 hi rise");
    idle(1'b0, 1'b1, 5, "R3 tail");
    // R7: retrigger mid pulse with a new width
    step(1'b0, 1'b0, 1'b1, 0, "R7 setup");
    step(1'b0, 1'b1, 1'b1, 4, "R7 first");
    idle(1'b0, 1'b1, 2, "R7 mid");
    step(1'b0, 1'b0, 1'b1, 0, "R7 drop");
    step(1'b0, 1'b1, 1'b1, 6, "R7 retrigger");
    idle(1'b0, 1'b1, 9, "R7 extended");
    // R8: clear during a pulse
    step(1'b0, 1'b0, 1'b1, 0, "R8 setup");
    step(1'b0, 1'b1, 1'b1, 9, "R8 start");
    idle(1'b0, 1'b1, 2, "R8 running");
    // R9: short clear; its release is inside the lockout
    step(1'b0, 1'b1, 1'b0, 9, "R8 clear drops");
    step(1'b0, 1'b1, 1'b1, 9, "R9 release locked");
    step(1'b0, 1'b0, 1'b1, 9, "R9 locked");
    step(1'b0, 1'b1, 1'b1, 9, "R9 rise locked");
    step(1'b0, 1'b0, 1'b1, 9, "R9 locked");
    idle(1'b0, 1'b0, 1, "R9 expiring");
    step(1'b0, 1'b1, 1'b1, 1, "R9 after lockout");
    idle(1'b0, 1'b1, 4, "R9 tail");
    // R4: long clear, release triggers
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 0, "R8 held clear");
    step(1'b0, 1'b1, 1'b1, 2, "R4 clear release");
    idle(1'b0, 1'b1, 5, "R4 tail");
    // R10 is checked on every item
    idle(1'b1, 1'b0, 3, "R10 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule